// File: doc/BRIEF.md
# Translated Single-Channel DMA Engine

This block is one DMA channel that moves device data to or from memory through an in-memory page table. Software programs three channel registers: a control/status word, a byte count and a logical start address. It also supplies a table base and a table limit. A device then raises a transfer request that carries a direction and a wanted length.

The engine first checks that the channel is enabled and that the request direction agrees with the programmed direction. It then clips the length to the remaining count. For every 4096-byte page the transfer touches, it fetches the page's table entry over a request/grant read port and turns the entry into a physical page frame. For each piece it emits a physical segment (address, length, direction) for the data mover. On completion it posts a terminal-count flag and lowers the count. On a refused request, an out-of-range page or a failing table read, it posts an error flag instead.

The channel registers sit at an 8-byte stride inside a 32-byte window. The outer decoder passes the word index (byte offset divided by 8) on `reg_sel`.

Top module: `ptx_dma_channel`

## Requirements
- R1: After reset every register index reads zero, `busy` is low and no memory read or segment is issued.
- R2: Index 1 (control/status), index 2 (count) and index 3 (logical address) read back the last written value. Control bit 0 enables the channel and bit 1 selects memory-to-device.
- R3: A request made while the channel is disabled, or whose `xfer_to_dev` differs from control bit 1, moves no data and issues no table read. It sets control bit 9 and sets bit `CHAN_ID` of the error-source word at index 0. The count is left unchanged.
- R4: Every accepted request first clears control bits 8, 9 and 10. When `done` pulses, exactly one of those three bits is set.
- R5: The moved length is the smaller of `xfer_len` and the count. On success control bit 8 is set and the count is reduced by that length. A zero length completes with bit 8 and no table read.
- R6: A table entry is read at address (`tbl_base` with bit 31 cleared) + 8 × page index, where the page index is the logical address shifted right by 12. The read request and address are held until granted.
- R7: A segment's physical address is the returned frame word with its low 12 bits cleared, OR-ed with the low 12 bits of the logical address.
- R8: If the page index is not below `tbl_limit`/8, no table read is made and no segment is issued. Control bit 10 is set and the count is unchanged.
- R9: A table read returning `mrd_rerr` aborts the transfer: control bit 10 is set, no further segment is issued and the count is unchanged.
- R10: A transfer crossing a page boundary is split into per-page segments, each translated by its own table read, and no segment crosses a page.
- R11: Writing a one to a bit of index 0 clears that error-source bit. A raise in the same cycle wins.
- R12: A request arriving while `busy` is high is ignored.
- R13: A request in the same cycle as a control write is judged against the control value before the write. The written value is kept except for bits 8 to 10, which take the engine's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register word index (0 error source, 1 control, 2 count, 3 address) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected index |
| tbl_base | input | 32 | Page table base address |
| tbl_limit | input | 32 | Page table size in bytes |
| xfer_req | input | 1 | Transfer request pulse |
| xfer_to_dev | input | 1 | Request direction, 1 = memory to device |
| xfer_len | input | CNT_W | Requested length in bytes |
| mrd_req | output | 1 | Table read request |
| mrd_addr | output | 32 | Table read address |
| mrd_gnt | input | 1 | Table read grant |
| mrd_rvalid | input | 1 | Table read data valid |
| mrd_rdata | input | 32 | Table read data (frame word) |
| mrd_rerr | input | 1 | Table read bus error |
| seg_valid | output | 1 | Segment strobe |
| seg_paddr | output | 32 | Segment physical address |
| seg_len | output | PAGE_BITS+1 | Segment length in bytes |
| seg_to_dev | output | 1 | Segment direction |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when a request has been resolved |

## Verification
The sharpest overlap is a software write to the control word landing in the same cycle as a transfer request. In that cycle both the register update and the engine's accept-or-refuse decision want the control word. The bench provokes it by driving `reg_wr` and `xfer_req` on the same clock edge while the channel is disabled, writing the enable bit. It judges the result at the ports. The request must be refused, so no table read is made and the error source is raised. The control word must then read back as the written enable bit together with the error flag. A second overlap, a request arriving one cycle after another, is provoked back to back. It is judged by counting segments and by the final count.

// File: rtl/ptx_pkg.sv
package ptx_pkg;

    localparam int ENTRY_SHIFT = 3;   // table entries are 8 bytes

    // control word bit positions
    localparam int CB_EN   = 0;
    localparam int CB_M2D  = 1;
    localparam int CB_TC   = 8;
    localparam int CB_FAIL = 9;
    localparam int CB_XLAT = 10;

    typedef enum logic [1:0] {
        SEL_ESRC = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_CNT  = 2'd2,
        SEL_ADDR = 2'd3
    } sel_e;

    // result codes placed into control bits 10:8
    localparam logic [2:0] RES_TC   = 3'b001;
    localparam logic [2:0] RES_FAIL = 3'b010;
    localparam logic [2:0] RES_XLAT = 3'b100;

    typedef struct packed {
        logic       clr;      // clear bits 10:8
        logic [2:0] set;      // result bits to set
        logic       raise;    // raise the channel's error-source bit
    } stat_t;

    typedef enum logic [1:0] { SQ_IDLE, SQ_WALK, SQ_ISSUE } seq_st_e;
    typedef enum logic [1:0] { WK_IDLE, WK_REQ, WK_RESP } walk_st_e;

    function automatic logic [31:0] entry_addr(input logic [31:0] base,
                                               input logic [31:0] page);
        return {1'b0, base[30:0]} + (page << ENTRY_SHIFT);
    endfunction

    function automatic logic page_ok(input logic [31:0] page,
                                     input logic [31:0] limit);
        return page < (limit >> ENTRY_SHIFT);
    endfunction

endpackage

// File: rtl/ptx_regfile.sv
module ptx_regfile
    import ptx_pkg::*;
#(
    parameter int CNT_W    = 24,
    parameter int NUM_CHAN = 4,
    parameter int CHAN_ID  = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [31:0]      wr_data,
    input  logic [1:0]       rd_sel,
    output logic [31:0]      rd_data,
    input  stat_t            stat,
    input  logic             cnt_commit,
    input  logic [CNT_W-1:0] cnt_sub,
    output logic [31:0]      ctrl_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic [31:0]      laddr_q
);
    logic [NUM_CHAN-1:0] esrc_q, esrc_n;
    logic [31:0]         ctrl_n, laddr_n;
    logic [CNT_W-1:0]    cnt_n;

    always_comb begin
        ctrl_n  = ctrl_q;
        cnt_n   = cnt_q;
        laddr_n = laddr_q;
        esrc_n  = esrc_q;
        if (wr_en) begin
            unique case (sel_e'(wr_sel))
                SEL_ESRC: esrc_n  = esrc_q & ~wr_data[NUM_CHAN-1:0];
                SEL_CTRL: ctrl_n  = wr_data;
                SEL_CNT:  cnt_n   = wr_data[CNT_W-1:0];
                SEL_ADDR: laddr_n = wr_data;
            endcase
        end
        if (stat.clr) ctrl_n[CB_XLAT:CB_TC] = 3'b000;
        ctrl_n[CB_XLAT:CB_TC] = ctrl_n[CB_XLAT:CB_TC] | stat.set;
        if (cnt_commit) cnt_n = cnt_q - cnt_sub;
        if (stat.raise) esrc_n[CHAN_ID] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            cnt_q   <= '0;
            laddr_q <= '0;
            esrc_q  <= '0;
        end else begin
            ctrl_q  <= ctrl_n;
            cnt_q   <= cnt_n;
            laddr_q <= laddr_n;
            esrc_q  <= esrc_n;
        end
    end

    always_comb begin
        unique case (sel_e'(rd_sel))
            SEL_ESRC: rd_data = 32'(esrc_q);
            SEL_CTRL: rd_data = ctrl_q;
            SEL_CNT:  rd_data = 32'(cnt_q);
            SEL_ADDR: rd_data = laddr_q;
        endcase
    end

    // R5: the count only moves on a software write or a completed transfer
    p_cnt_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_sel == SEL_CNT) && !cnt_commit |=> $stable(cnt_q));

    // R3 / R11: the error-source bit is sticky until written with a one
    p_esrc_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        esrc_q[CHAN_ID] && !(wr_en && wr_sel == SEL_ESRC && wr_data[CHAN_ID])
        |=> esrc_q[CHAN_ID]);

endmodule

// File: rtl/ptx_walker.sv
module ptx_walker
    import ptx_pkg::*;
#(
    parameter int PAGE_BITS = 12
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wk_start,
    input  logic [31:0] wk_laddr,
    input  logic [31:0] tbl_base,
    input  logic [31:0] tbl_limit,
    output logic        mrd_req,
    output logic [31:0] mrd_addr,
    input  logic        mrd_gnt,
    input  logic        mrd_rvalid,
    input  logic [31:0] mrd_rdata,
    input  logic        mrd_rerr,
    output logic        wk_done,
    output logic        wk_fault,
    output logic [31:0] wk_frame
);
    localparam logic [31:0] OFS_MASK = (32'd1 << PAGE_BITS) - 32'd1;

    walk_st_e    st_q;
    logic [31:0] addr_q;
    logic [31:0] page;

    assign page     = wk_laddr >> PAGE_BITS;
    assign mrd_req  = (st_q == WK_REQ);
    assign mrd_addr = addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= WK_IDLE;
            addr_q   <= '0;
            wk_done  <= 1'b0;
            wk_fault <= 1'b0;
            wk_frame <= '0;
        end else begin
            wk_done <= 1'b0;
            unique case (st_q)
                WK_IDLE: if (wk_start) begin
                    if (!page_ok(page, tbl_limit)) begin
                        wk_done  <= 1'b1;
                        wk_fault <= 1'b1;
                    end else begin
                        addr_q <= entry_addr(tbl_base, page);
                        st_q   <= WK_REQ;
                    end
                end
                WK_REQ: if (mrd_gnt) st_q <= WK_RESP;
                WK_RESP: if (mrd_rvalid) begin
                    wk_done  <= 1'b1;
                    wk_fault <= mrd_rerr;
                    wk_frame <= mrd_rdata & ~OFS_MASK;
                    st_q     <= WK_IDLE;
                end
                default: st_q <= WK_IDLE;
            endcase
        end
    end

    // R6: a pending table read keeps its request and address until granted
    p_req_hold_r6: assert property (@(posedge clk) disable iff (rst)
        mrd_req && !mrd_gnt |=> mrd_req && $stable(mrd_addr));

    // R7: a delivered frame never carries page-offset bits
    p_frame_clean_r7: assert property (@(posedge clk) disable iff (rst)
        wk_done && !wk_fault |-> (wk_frame & OFS_MASK) == 32'd0);

endmodule

// File: rtl/ptx_seq.sv
module ptx_seq
    import ptx_pkg::*;
#(
    parameter int CNT_W     = 24,
    parameter int PAGE_BITS = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 xfer_req,
    input  logic                 xfer_to_dev,
    input  logic [CNT_W-1:0]     xfer_len,
    input  logic                 ctl_en,
    input  logic                 ctl_m2d,
    input  logic [CNT_W-1:0]     cnt,
    input  logic [31:0]          laddr,
    output logic                 wk_start,
    output logic [31:0]          wk_laddr,
    input  logic                 wk_done,
    input  logic                 wk_fault,
    input  logic [31:0]          wk_frame,
    output logic                 seg_valid,
    output logic [31:0]          seg_paddr,
    output logic [PAGE_BITS:0]   seg_len,
    output logic                 seg_to_dev,
    output stat_t                stat,
    output logic                 cnt_commit,
    output logic [CNT_W-1:0]     cnt_sub,
    output logic                 busy,
    output logic                 done
);
    localparam logic [PAGE_BITS:0] PAGE_SZ = (PAGE_BITS+1)'(1) << PAGE_BITS;

    seq_st_e          st_q;
    logic [31:0]      cur_q;
    logic [CNT_W-1:0] rem_q, tot_q;
    logic             dir_q;
    logic [31:0]      frame_q;

    logic             refuse;
    logic [CNT_W-1:0] req_len;
    logic [PAGE_BITS:0] room;
    logic             fits;

    assign refuse   = !ctl_en || (xfer_to_dev != ctl_m2d);
    assign req_len  = (xfer_len < cnt) ? xfer_len : cnt;
    assign room     = PAGE_SZ - {1'b0, cur_q[PAGE_BITS-1:0]};
    assign fits     = 32'(rem_q) <= 32'(room);

    assign busy       = (st_q != SQ_IDLE);
    assign wk_laddr   = cur_q;
    assign seg_valid  = (st_q == SQ_ISSUE);
    assign seg_paddr  = {frame_q[31:PAGE_BITS], cur_q[PAGE_BITS-1:0]};
    assign seg_len    = fits ? (PAGE_BITS+1)'(rem_q) : room;
    assign seg_to_dev = dir_q;
    assign cnt_sub    = tot_q;

    always_comb begin
        stat       = '0;
        cnt_commit = 1'b0;
        unique case (st_q)
            SQ_IDLE: if (xfer_req) begin
                stat.clr = 1'b1;
                if (refuse) begin
                    stat.set   = RES_FAIL;
                    stat.raise = 1'b1;
                end else if (req_len == '0) begin
                    stat.set = RES_TC;
                end
            end
            SQ_WALK: if (wk_done && wk_fault) stat.set = RES_XLAT;
            SQ_ISSUE: if (fits) begin
                stat.set   = RES_TC;
                cnt_commit = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= SQ_IDLE;
            cur_q    <= '0;
            rem_q    <= '0;
            tot_q    <= '0;
            dir_q    <= 1'b0;
            frame_q  <= '0;
            wk_start <= 1'b0;
            done     <= 1'b0;
        end else begin
            wk_start <= 1'b0;
            done     <= 1'b0;
            unique case (st_q)
                SQ_IDLE: if (xfer_req) begin
                    if (refuse || req_len == '0) begin
                        done <= 1'b1;
                    end else begin
                        cur_q    <= laddr;
                        rem_q    <= req_len;
                        tot_q    <= req_len;
                        dir_q    <= xfer_to_dev;
                        wk_start <= 1'b1;
                        st_q     <= SQ_WALK;
                    end
                end
                SQ_WALK: if (wk_done) begin
                    if (wk_fault) begin
                        done <= 1'b1;
                        st_q <= SQ_IDLE;
                    end else begin
                        frame_q <= wk_frame;
                        st_q    <= SQ_ISSUE;
                    end
                end
                SQ_ISSUE: begin
                    if (fits) begin
                        done <= 1'b1;
                        st_q <= SQ_IDLE;
                    end else begin
                        cur_q    <= cur_q + 32'(room);
                        rem_q    <= rem_q - CNT_W'(room);
                        wk_start <= 1'b1;
                        st_q     <= SQ_WALK;
                    end
                end
                default: st_q <= SQ_IDLE;
            endcase
        end
    end

    // R10: no segment runs past the end of its page
    p_seg_in_page_r10: assert property (@(posedge clk) disable iff (rst)
        seg_valid |-> (32'(seg_paddr[PAGE_BITS-1:0]) + 32'(seg_len)) <= 32'(PAGE_SZ)
                      && seg_len != '0);

    // R8 / R9: a failed lookup is never followed by a segment
    p_fault_no_seg_r8: assert property (@(posedge clk) disable iff (rst)
        busy && wk_done && wk_fault |=> !seg_valid && !busy);

    // R12: the engine is idle whenever it signals completion
    p_idle_at_done_r12: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

endmodule

// File: rtl/ptx_dma_channel.sv
module ptx_dma_channel
    import ptx_pkg::*;
#(
    parameter int CNT_W     = 24,
    parameter int PAGE_BITS = 12,
    parameter int NUM_CHAN  = 4,
    parameter int CHAN_ID   = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr,
    input  logic [1:0]           reg_sel,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic [31:0]          tbl_base,
    input  logic [31:0]          tbl_limit,
    input  logic                 xfer_req,
    input  logic                 xfer_to_dev,
    input  logic [CNT_W-1:0]     xfer_len,
    output logic                 mrd_req,
    output logic [31:0]          mrd_addr,
    input  logic                 mrd_gnt,
    input  logic                 mrd_rvalid,
    input  logic [31:0]          mrd_rdata,
    input  logic                 mrd_rerr,
    output logic                 seg_valid,
    output logic [31:0]          seg_paddr,
    output logic [PAGE_BITS:0]   seg_len,
    output logic                 seg_to_dev,
    output logic                 busy,
    output logic                 done
);
    stat_t            stat;
    logic             cnt_commit;
    logic [CNT_W-1:0] cnt_sub, cnt_q;
    logic [31:0]      ctrl_q, laddr_q;
    logic             wk_start, wk_done, wk_fault;
    logic [31:0]      wk_laddr, wk_frame;

    ptx_regfile #(.CNT_W(CNT_W), .NUM_CHAN(NUM_CHAN), .CHAN_ID(CHAN_ID)) u_regs (
        .clk(clk), .rst(rst),
        .wr_en(reg_wr), .wr_sel(reg_sel), .wr_data(reg_wdata),
        .rd_sel(reg_sel), .rd_data(reg_rdata),
        .stat(stat), .cnt_commit(cnt_commit), .cnt_sub(cnt_sub),
        .ctrl_q(ctrl_q), .cnt_q(cnt_q), .laddr_q(laddr_q)
    );

    ptx_seq #(.CNT_W(CNT_W), .PAGE_BITS(PAGE_BITS)) u_seq (
        .clk(clk), .rst(rst),
        .xfer_req(xfer_req), .xfer_to_dev(xfer_to_dev), .xfer_len(xfer_len),
        .ctl_en(ctrl_q[CB_EN]), .ctl_m2d(ctrl_q[CB_M2D]),
        .cnt(cnt_q), .laddr(laddr_q),
        .wk_start(wk_start), .wk_laddr(wk_laddr),
        .wk_done(wk_done), .wk_fault(wk_fault), .wk_frame(wk_frame),
        .seg_valid(seg_valid), .seg_paddr(seg_paddr), .seg_len(seg_len),
        .seg_to_dev(seg_to_dev),
        .stat(stat), .cnt_commit(cnt_commit), .cnt_sub(cnt_sub),
        .busy(busy), .done(done)
    );

    ptx_walker #(.PAGE_BITS(PAGE_BITS)) u_walk (
        .clk(clk), .rst(rst),
        .wk_start(wk_start), .wk_laddr(wk_laddr),
        .tbl_base(tbl_base), .tbl_limit(tbl_limit),
        .mrd_req(mrd_req), .mrd_addr(mrd_addr), .mrd_gnt(mrd_gnt),
        .mrd_rvalid(mrd_rvalid), .mrd_rdata(mrd_rdata), .mrd_rerr(mrd_rerr),
        .wk_done(wk_done), .wk_fault(wk_fault), .wk_frame(wk_frame)
    );

    // R4: every resolved request leaves exactly one result bit
    p_one_result_r4: assert property (@(posedge clk) disable iff (rst)
        done |-> $countones(ctrl_q[CB_XLAT:CB_TC]) == 1);

endmodule

// File: tb/test_ptx_dma_channel.sv
module test_ptx_dma_channel;
    localparam int CNT_W = 24;
    localparam int PB    = 12;
    localparam logic [31:0] BASE  = 32'h8000_4000;
    localparam logic [31:0] BASEC = 32'h0000_4000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;   // 250 MHz

    logic             reg_wr = 1'b0;
    logic [1:0]       reg_sel = 2'd0;
    logic [31:0]      reg_wdata = '0;
    logic [31:0]      reg_rdata;
    logic [31:0]      tbl_base = BASE;
    logic [31:0]      tbl_limit = 32'h100;
    logic             xfer_req = 1'b0;
    logic             xfer_to_dev = 1'b0;
    logic [CNT_W-1:0] xfer_len = '0;
    logic             mrd_req, mrd_gnt;
    logic [31:0]      mrd_addr;
    logic             mrd_rvalid = 1'b0;
    logic [31:0]      mrd_rdata = '0;
    logic             mrd_rerr = 1'b0;
    logic             seg_valid, seg_to_dev, busy, done;
    logic [31:0]      seg_paddr;
    logic [PB:0]      seg_len;

    ptx_dma_channel i_ptx_dma_channel (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tbl_base(tbl_base), .tbl_limit(tbl_limit),
        .xfer_req(xfer_req), .xfer_to_dev(xfer_to_dev), .xfer_len(xfer_len),
        .mrd_req(mrd_req), .mrd_addr(mrd_addr), .mrd_gnt(mrd_gnt),
        .mrd_rvalid(mrd_rvalid), .mrd_rdata(mrd_rdata), .mrd_rerr(mrd_rerr),
        .seg_valid(seg_valid), .seg_paddr(seg_paddr), .seg_len(seg_len),
        .seg_to_dev(seg_to_dev), .busy(busy), .done(done)
    );

    int checks = 0;
    int errors = 0;
    logic [31:0] err_addr = 32'hFFFF_FFFF;

    // table memory model: frame word is a function of the entry address
    function automatic logic [31:0] frame_of(input logic [31:0] a);
        return {a[19:0], 12'h5A5} ^ 32'h0300_0000;
    endfunction
    function automatic logic [31:0] exp_pa(input int page, input logic [31:0] ofs);
        return (frame_of(BASEC + 32'(page) * 8) & 32'hFFFF_F000) | ofs;
    endfunction

    int          nreads = 0;
    logic [31:0] last_raddr = '0;
    assign mrd_gnt = mrd_req;
    always @(posedge clk) begin
        mrd_rvalid <= 1'b0;
        if (mrd_req && mrd_gnt) begin
            mrd_rvalid <= 1'b1;
            mrd_rdata  <= frame_of(mrd_addr);
            mrd_rerr   <= (mrd_addr == err_addr);
            last_raddr <= mrd_addr;
            nreads     <= nreads + 1;
        end
    end

    int          nsegs = 0;
    logic [31:0] sp [0:15];
    int          sl [0:15];
    logic        sd [0:15];
    always @(negedge clk) begin
        if (seg_valid && nsegs < 16) begin
            sp[nsegs] <= seg_paddr;
            sl[nsegs] <= int'(seg_len);
            sd[nsegs] <= seg_to_dev;
            nsegs     <= nsegs + 1;
        end
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] d);
        @(negedge clk);
        reg_sel = sel;
        #1 d = reg_rdata;
    endtask

    task automatic request(input logic to_dev, input int len);
        @(negedge clk);
        xfer_req = 1'b1; xfer_to_dev = to_dev; xfer_len = CNT_W'(len);
        @(posedge clk); #1;
        xfer_req = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (n < 200) begin
            @(negedge clk);
            if (done) break;
            n++;
        end
        if (n >= 200) begin
            checks++; errors++;
            $display("FAIL %s no done pulse got 0 expected 1", tag);
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic setup(input logic [31:0] ctl, input logic [31:0] cnt, input logic [31:0] la);
        wr(2'd1, ctl); wr(2'd2, cnt); wr(2'd3, la);
    endtask

    logic [31:0] v;
    int r0, s0;

    task automatic t_reset();
        for (int i = 0; i < 4; i++) begin
            rd(2'(i), v); check("R1 reg after reset", v, 32'h0);
        end
        check("R1 busy after reset", 32'(busy), 32'h0);
        check("R1 no reads after reset", 32'(nreads), 32'h0);
    endtask

    task automatic t_readback();
        setup(32'h3, 32'h100, 32'h1234);
        rd(2'd1, v); check("R2 control readback", v, 32'h3);
        rd(2'd2, v); check("R2 count readback", v, 32'h100);
        rd(2'd3, v); check("R2 address readback", v, 32'h1234);
    endtask

    task automatic t_disabled();
        wr(2'd1, 32'h0);
        r0 = nreads; s0 = nsegs;
        request(1'b0, 16); wait_done("R3 disabled");
        rd(2'd1, v); check("R3 disabled sets bit 9", v, 32'h200);
        rd(2'd0, v); check("R3 error source raised", v, 32'h1);
        rd(2'd2, v); check("R3 count unchanged", v, 32'h100);
        check("R3 no table read", 32'(nreads - r0), 32'h0);
        check("R3 no segment", 32'(nsegs - s0), 32'h0);
        wr(2'd0, 32'h1);
        rd(2'd0, v); check("R11 write-one clears error source", v, 32'h0);
    endtask

    task automatic t_mismatch();
        wr(2'd1, 32'h3);
        r0 = nreads;
        request(1'b0, 16); wait_done("R3 mismatch");
        rd(2'd1, v); check("R3 direction mismatch bit 9", v, 32'h203);
        rd(2'd0, v); check("R3 mismatch error source", v, 32'h1);
        check("R3 mismatch no read", 32'(nreads - r0), 32'h0);
        wr(2'd0, 32'h1);
    endtask

    task automatic t_single();
        setup(32'h701, 32'h80, 32'h3010);
        r0 = nreads; s0 = nsegs;
        request(1'b0, 32'h200); wait_done("R5 single");
        check("R6 one table read", 32'(nreads - r0), 32'h1);
        check("R6 entry address", last_raddr, 32'h4018);
        check("R10 one segment", 32'(nsegs - s0), 32'h1);
        check("R7 physical address", sp[s0], exp_pa(3, 32'h010));
        check("R5 length clipped to count", 32'(sl[s0]), 32'h80);
        check("R2 segment direction", 32'(sd[s0]), 32'h0);
        rd(2'd1, v); check("R4 old flags cleared, bit 8 set", v, 32'h101);
        rd(2'd2, v); check("R5 count reduced", v, 32'h0);
        setup(32'h1, 32'h1000, 32'h2000);
        s0 = nsegs;
        request(1'b0, 32'h40); wait_done("R5 clip");
        check("R5 length clipped to request", 32'(sl[s0]), 32'h40);
        rd(2'd2, v); check("R5 count after short request", v, 32'hFC0);
    endtask

    task automatic t_cross();
        setup(32'h3, 32'h200, 32'h5F80);
        r0 = nreads; s0 = nsegs;
        request(1'b1, 32'h200); wait_done("R10 cross");
        check("R10 two table reads", 32'(nreads - r0), 32'h2);
        check("R10 second entry address", last_raddr, 32'h4030);
        check("R10 two segments", 32'(nsegs - s0), 32'h2);
        check("R10 first segment address", sp[s0], exp_pa(5, 32'hF80));
        check("R10 first segment length", 32'(sl[s0]), 32'h80);
        check("R10 second segment address", sp[s0+1], exp_pa(6, 32'h0));
        check("R10 second segment length", 32'(sl[s0+1]), 32'h180);
        check("R10 direction to device", 32'(sd[s0+1]), 32'h1);
        rd(2'd2, v); check("R5 count after crossing", v, 32'h0);
        rd(2'd1, v); check("R4 flags after crossing", v, 32'h103);
    endtask

    task automatic t_limit();
        setup(32'h1, 32'h40, 32'h1F000);
        s0 = nsegs;
        request(1'b0, 32'h40); wait_done("R8 last page");
        check("R8 last page inside limit", 32'(nsegs - s0), 32'h1);
        setup(32'h1, 32'h40, 32'h20000);
        r0 = nreads; s0 = nsegs;
        request(1'b0, 32'h40); wait_done("R8 beyond");
        rd(2'd1, v); check("R8 beyond limit bit 10", v, 32'h401);
        check("R8 no table read", 32'(nreads - r0), 32'h0);
        check("R8 no segment", 32'(nsegs - s0), 32'h0);
        rd(2'd2, v); check("R8 count unchanged", v, 32'h40);
    endtask

    task automatic t_buserr();
        err_addr = BASEC + 32'd7 * 8;
        setup(32'h1, 32'h40, 32'h7000);
        r0 = nreads; s0 = nsegs;
        request(1'b0, 32'h40); wait_done("R9 bus error");
        rd(2'd1, v); check("R9 bus error bit 10", v, 32'h401);
        check("R9 one table read", 32'(nreads - r0), 32'h1);
        check("R9 no segment", 32'(nsegs - s0), 32'h0);
        rd(2'd2, v); check("R9 count unchanged", v, 32'h40);
        err_addr = 32'hFFFF_FFFF;
    endtask

    task automatic t_zero();
        setup(32'h1, 32'h0, 32'h1000);
        r0 = nreads;
        request(1'b0, 32'h40); wait_done("R5 zero");
        rd(2'd1, v); check("R5 zero length completes", v, 32'h101);
        check("R5 zero length no read", 32'(nreads - r0), 32'h0);
    endtask

    task automatic t_busy();
        setup(32'h1, 32'h300, 32'h1000);
        s0 = nsegs;
        request(1'b0, 32'h100);
        request(1'b0, 32'h100);
        wait_done("R12 busy");
        repeat (20) @(negedge clk);
        check("R12 second request ignored", 32'(nsegs - s0), 32'h1);
        rd(2'd2, v); check("R12 count after one transfer", v, 32'h200);
    endtask

    task automatic t_collide();
        wr(2'd1, 32'h0);
        r0 = nreads;
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 2'd1; reg_wdata = 32'h1;
        xfer_req = 1'b1; xfer_to_dev = 1'b0; xfer_len = CNT_W'(4);
        @(posedge clk); #1;
        reg_wr = 1'b0; xfer_req = 1'b0;
        wait_done("R13 collide");
        rd(2'd1, v); check("R13 write kept, old value judged", v, 32'h201);
        rd(2'd0, v); check("R13 error source raised", v, 32'h1);
        check("R13 no table read", 32'(nreads - r0), 32'h0);
    endtask

    bit finished = 0;
    initial begin
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_readback();
        t_disabled();
        t_mismatch();
        t_single();
        t_cross();
        t_limit();
        t_buserr();
        t_zero();
        t_busy();
        t_collide();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule